// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the processor-side engine that lays down and later tears down the stack frame for an interrupt or an exception. When an entry is requested, it compares the privilege level of the running code with that of the handler. If the two differ, it switches to the stack pointer and stack segment given for the handler's level. It then saves the interrupted context by writing one 32-bit word per cycle to a memory-write port, moving downward through the stack. A gate-type input decides whether the interrupt-enable flag is cleared in the flags value handed to the handler.

When a return is requested, the block walks back up the same frame, reading one word per cycle. It first skips an error code if one is present. It then restores the instruction pointer, the code selector and the flags. When the restored code selector shows that the privilege level changes back, it also restores the old stack pointer and stack segment.

Descriptor lookup, segment checks and instruction decode belong to other logic. Stack memory is external and is read asynchronously: read data is valid in the same cycle as the address.

Top module: `irq_frame_seq`

## Requirements
- R1: When `cur_pl` equals `ent_dst_pl`, an entry writes three words at descending addresses, starting 4 below `cur_esp`: flags first, then code selector, then instruction pointer. Selectors are written zero-extended to 32 bits.
- R2: When `cur_pl` differs from `ent_dst_pl`, an entry starts from `ent_new_esp` instead. Before the three words of R1, it writes the old stack segment and then the old stack pointer.
- R3: When `ent_has_err` is 1, the entry writes `ent_err` as one extra word after the instruction pointer, at the lowest address of the frame.
- R4: At the end of an entry, `out_eflags` equals the saved flags with bit 9 (interrupt enable) cleared when `ent_is_trap` is 0, and with bit 9 unchanged when `ent_is_trap` is 1. At the same point, `out_esp` is the lowest frame address, `out_ss` is the stack segment in use and `out_pl` is `ent_dst_pl`.
- R5: A return skips one word when `ret_has_err` is 1. It then reads the instruction pointer, code selector and flags into `out_eip`, `out_cs` and `out_eflags`, and sets `out_pl` to bits 1:0 of the restored code selector. If those bits differ from `cur_pl`, it also reads the stack pointer and then the stack segment into `out_esp` and `out_ss`. Otherwise `out_esp` is the address just above the frame and `out_ss` is `cur_ss`.
- R6: Each write uses an address 4 below the previous stack pointer. Each read uses the current pointer, which then rises by 4. Consecutive writes therefore step down by 4, and consecutive reads step up by 4.
- R7: `busy` is high for exactly one cycle per stack access, starting in the cycle after the start is accepted. `done` is a one-cycle pulse in the cycle after the last access, and `busy` is low in that cycle.
- R8: The output registers (`out_eflags` among them) change only in the cycle in which `done` is high. The restored interrupt-enable bit therefore appears together with `done`.
- R9: `ent_start` and `ret_start` are ignored while `busy` is high. When both are high in an idle cycle, the entry is taken.
- R10: After reset, `busy`, `done`, `mem_wr_en` and `mem_rd_en` are 0 and all output registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ent_start | input | 1 | Request an entry sequence |
| ent_is_trap | input | 1 | 1: trap gate (keep interrupt enable); 0: interrupt gate (clear it) |
| ent_dst_pl | input | 2 | Privilege level of the handler |
| ent_has_err | input | 1 | Entry carries an error code |
| ent_err | input | 32 | Error code value |
| ent_new_esp | input | 32 | Stack pointer for the handler level |
| ent_new_ss | input | 16 | Stack segment for the handler level |
| ret_start | input | 1 | Request a return sequence |
| ret_has_err | input | 1 | Frame holds an error code to skip |
| cur_pl | input | 2 | Current privilege level |
| cur_ss | input | 16 | Current stack segment |
| cur_esp | input | 32 | Current stack pointer |
| cur_eflags | input | 32 | Current flags |
| cur_cs | input | 16 | Current code selector |
| cur_eip | input | 32 | Current instruction pointer |
| mem_wr_en | output | 1 | Stack write strobe |
| mem_rd_en | output | 1 | Stack read strobe |
| mem_addr | output | 32 | Stack byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the same cycle as the address |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| out_pl | output | 2 | Resulting privilege level |
| out_ss | output | 16 | Resulting stack segment |
| out_esp | output | 32 | Resulting stack pointer |
| out_eflags | output | 32 | Resulting flags |
| out_cs | output | 16 | Restored code selector |
| out_eip | output | 32 | Restored instruction pointer |

## Verification
The hardest case to reach from the ports is a return whose length is only known partway through, once the restored selector has been read. Reaching it requires a frame that the block built itself with a privilege change, followed by a return issued at the handler's level. The bench sweeps every pair of current and handler levels, with and without an error code, for both gate types. Each entry is followed by the matching return on the same memory model. During the second busy cycle of every entry, both start inputs are pulsed to show that a request arriving mid-sequence has no effect.

// File: rtl/irq_frame_pkg.sv
package irq_frame_pkg;
  typedef enum logic [2:0] {
    K_SS  = 3'd0,
    K_ESP = 3'd1,
    K_FLG = 3'd2,
    K_CS  = 3'd3,
    K_EIP = 3'd4,
    K_ERR = 3'd5
  } slot_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_PUSH = 2'd1,
    S_POP  = 2'd2
  } seq_e;
endpackage

// File: rtl/irq_step_order.sv
module irq_step_order
  import irq_frame_pkg::*;
(
  input  logic  pop_dir,
  input  logic  lvl_chg,
  input  logic  has_err,
  input  slot_e cur,
  output slot_e nxt,
  output logic  last
);
  always_comb begin
    nxt  = cur;
    last = 1'b0;
    if (!pop_dir) begin
      unique case (cur)
        K_SS:    nxt = K_ESP;
        K_ESP:   nxt = K_FLG;
        K_FLG:   nxt = K_CS;
        K_CS:    nxt = K_EIP;
        K_EIP:   if (has_err) nxt = K_ERR; else last = 1'b1;
        default: last = 1'b1;
      endcase
    end else begin
      unique case (cur)
        K_ERR:   nxt = K_EIP;
        K_EIP:   nxt = K_CS;
        K_CS:    nxt = K_FLG;
        K_FLG:   if (lvl_chg) nxt = K_ESP; else last = 1'b1;
        K_ESP:   nxt = K_SS;
        default: last = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/irq_stack_ptr.sv
module irq_stack_ptr #(
  parameter int DW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          push,
  input  logic          pop,
  output logic [DW-1:0] ptr_q,
  output logic [DW-1:0] acc_addr
);
  localparam logic [DW-1:0] STEP_V = DW'(STEP);
  logic [DW-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (load)      ptr_d = load_val;
    else if (push) ptr_d = ptr_q - STEP_V;
    else if (pop)  ptr_d = ptr_q + STEP_V;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign acc_addr = push ? (ptr_q - STEP_V) : ptr_q;

  AST_PTR_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop)); // R6
  AST_PTR_PUSH_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !load) |=> (ptr_q == $past(acc_addr))); // R6
endmodule

// File: rtl/irq_frame_seq.sv
module irq_frame_seq
  import irq_frame_pkg::*;
#(
  parameter int DW     = 32,
  parameter int SELW   = 16,
  parameter int PLW    = 2,
  parameter int IF_BIT = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ent_start,
  input  logic            ent_is_trap,
  input  logic [PLW-1:0]  ent_dst_pl,
  input  logic            ent_has_err,
  input  logic [DW-1:0]   ent_err,
  input  logic [DW-1:0]   ent_new_esp,
  input  logic [SELW-1:0] ent_new_ss,
  input  logic            ret_start,
  input  logic            ret_has_err,
  input  logic [PLW-1:0]  cur_pl,
  input  logic [SELW-1:0] cur_ss,
  input  logic [DW-1:0]   cur_esp,
  input  logic [DW-1:0]   cur_eflags,
  input  logic [SELW-1:0] cur_cs,
  input  logic [DW-1:0]   cur_eip,
  output logic            mem_wr_en,
  output logic            mem_rd_en,
  output logic [DW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic            busy,
  output logic            done,
  output logic [PLW-1:0]  out_pl,
  output logic [SELW-1:0] out_ss,
  output logic [DW-1:0]   out_esp,
  output logic [DW-1:0]   out_eflags,
  output logic [SELW-1:0] out_cs,
  output logic [DW-1:0]   out_eip
);
  localparam int            STEP   = DW / 8;
  localparam logic [DW-1:0] STEP_V = DW'(STEP);
  localparam logic [DW-1:0] IF_MSK = DW'(1) << IF_BIT;

  seq_e  st_q, st_d;
  slot_e kind_q, kind_d, kind_nxt;
  logic  kind_last;
  logic  chg_q, chg_d, err_q, err_d, trap_q, trap_d, done_q, done_d;
  logic [PLW-1:0]  dpl_q, dpl_d, cpl_q, cpl_d;
  logic [SELW-1:0] nss_q, nss_d, oss_q, oss_d, cs_q, cs_d;
  logic [DW-1:0]   oesp_q, oesp_d, flg_q, flg_d, eip_q, eip_d, errv_q, errv_d;
  logic [PLW-1:0]  opl_q, opl_d;
  logic [SELW-1:0] oss_out_q, oss_out_d, ocs_q, ocs_d;
  logic [DW-1:0]   oesp_out_q, oesp_out_d, ofl_q, ofl_d, oeip_q, oeip_d;
  logic            ptr_load, do_push, do_pop;
  logic [DW-1:0]   ptr_val, ptr_q, acc_addr;
  logic            entry_chg;

  assign entry_chg = (cur_pl != ent_dst_pl);
  assign do_push   = (st_q == S_PUSH);
  assign do_pop    = (st_q == S_POP);

  irq_step_order u_order (
    .pop_dir (do_pop),
    .lvl_chg (chg_q),
    .has_err (err_q),
    .cur     (kind_q),
    .nxt     (kind_nxt),
    .last    (kind_last)
  );

  irq_stack_ptr #(.DW(DW), .STEP(STEP)) u_sp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ptr_load),
    .load_val (ptr_val),
    .push     (do_push),
    .pop      (do_pop),
    .ptr_q    (ptr_q),
    .acc_addr (acc_addr)
  );

  always_comb begin
    st_d = st_q;     kind_d = kind_q;  chg_d = chg_q;   err_d = err_q;
    trap_d = trap_q; dpl_d = dpl_q;    cpl_d = cpl_q;   nss_d = nss_q;
    oss_d = oss_q;   oesp_d = oesp_q;  flg_d = flg_q;   cs_d = cs_q;
    eip_d = eip_q;   errv_d = errv_q;  done_d = 1'b0;
    opl_d = opl_q;   oss_out_d = oss_out_q; oesp_out_d = oesp_out_q;
    ofl_d = ofl_q;   ocs_d = ocs_q;    oeip_d = oeip_q;
    ptr_load = 1'b0; ptr_val = cur_esp;
    mem_wdata = '0;
    unique case (st_q)
      S_IDLE: begin
        if (ent_start) begin
          st_d   = S_PUSH;
          chg_d  = entry_chg;
          kind_d = entry_chg ? K_SS : K_FLG;
          err_d  = ent_has_err;  trap_d = ent_is_trap; dpl_d = ent_dst_pl;
          nss_d  = ent_new_ss;   oss_d  = cur_ss;      oesp_d = cur_esp;
          flg_d  = cur_eflags;   cs_d   = cur_cs;      eip_d  = cur_eip;
          errv_d = ent_err;
          ptr_load = 1'b1;
          ptr_val  = entry_chg ? ent_new_esp : cur_esp;
        end else if (ret_start) begin
          st_d   = S_POP;
          chg_d  = 1'b0;
          kind_d = ret_has_err ? K_ERR : K_EIP;
          err_d  = ret_has_err;  cpl_d = cur_pl; oss_d = cur_ss;
          ptr_load = 1'b1;
          ptr_val  = cur_esp;
        end
      end
      S_PUSH: begin
        unique case (kind_q)
          K_SS:    mem_wdata = {{(DW-SELW){1'b0}}, oss_q};
          K_ESP:   mem_wdata = oesp_q;
          K_FLG:   mem_wdata = flg_q;
          K_CS:    mem_wdata = {{(DW-SELW){1'b0}}, cs_q};
          K_EIP:   mem_wdata = eip_q;
          default: mem_wdata = errv_q;
        endcase
        if (kind_last) begin
          st_d = S_IDLE;  done_d = 1'b1;
          oss_out_d  = chg_q ? nss_q : oss_q;
          oesp_out_d = acc_addr;
          ofl_d      = trap_q ? flg_q : (flg_q & ~IF_MSK);
          opl_d      = dpl_q;
        end else begin
          kind_d = kind_nxt;
        end
      end
      S_POP: begin
        unique case (kind_q)
          K_EIP: eip_d = mem_rdata;
          K_CS: begin
            cs_d  = mem_rdata[SELW-1:0];
            chg_d = (mem_rdata[PLW-1:0] != cpl_q);
          end
          K_FLG:   flg_d  = mem_rdata;
          K_ESP:   oesp_d = mem_rdata;
          default: ;
        endcase
        if (kind_last) begin
          st_d = S_IDLE;  done_d = 1'b1;
          oeip_d     = eip_q;
          ocs_d      = cs_q;
          opl_d      = cs_q[PLW-1:0];
          ofl_d      = chg_q ? flg_q : mem_rdata;
          oesp_out_d = chg_q ? oesp_q : (ptr_q + STEP_V);
          oss_out_d  = chg_q ? mem_rdata[SELW-1:0] : oss_q;
        end else begin
          kind_d = kind_nxt;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;  kind_q <= K_FLG; chg_q <= 1'b0; err_q <= 1'b0;
      trap_q <= 1'b0;  dpl_q <= '0;     cpl_q <= '0;   nss_q <= '0;
      oss_q <= '0;     oesp_q <= '0;    flg_q <= '0;   cs_q <= '0;
      eip_q <= '0;     errv_q <= '0;    done_q <= 1'b0;
      opl_q <= '0;     oss_out_q <= '0; oesp_out_q <= '0;
      ofl_q <= '0;     ocs_q <= '0;     oeip_q <= '0;
    end else begin
      st_q <= st_d;    kind_q <= kind_d; chg_q <= chg_d; err_q <= err_d;
      trap_q <= trap_d; dpl_q <= dpl_d;  cpl_q <= cpl_d; nss_q <= nss_d;
      oss_q <= oss_d;  oesp_q <= oesp_d; flg_q <= flg_d; cs_q <= cs_d;
      eip_q <= eip_d;  errv_q <= errv_d; done_q <= done_d;
      opl_q <= opl_d;  oss_out_q <= oss_out_d; oesp_out_q <= oesp_out_d;
      ofl_q <= ofl_d;  ocs_q <= ocs_d;   oeip_q <= oeip_d;
    end
  end

  assign mem_wr_en  = do_push;
  assign mem_rd_en  = do_pop;
  assign mem_addr   = acc_addr;
  assign busy       = (st_q != S_IDLE);
  assign done       = done_q;
  assign out_pl     = opl_q;
  assign out_ss     = oss_out_q;
  assign out_esp    = oesp_out_q;
  assign out_eflags = ofl_q;
  assign out_cs     = ocs_q;
  assign out_eip    = oeip_q;

  AST_WR_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> (!mem_wr_en || mem_addr == $past(mem_addr) - STEP_V)); // R6
  AST_RD_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> (!mem_rd_en || mem_addr == $past(mem_addr) + STEP_V)); // R6
  AST_ACCESS_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en || mem_rd_en) |-> busy); // R7
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(out_eflags) && $stable(out_esp) && $stable(out_eip))); // R8
  AST_IF_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(st_q == S_PUSH) && !trap_q) |-> !out_eflags[IF_BIT]); // R4
endmodule

// File: tb/irq_frame_seq_tb.sv
`timescale 1ns/1ps
module irq_frame_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ent_start, ent_is_trap, ent_has_err, ret_start, ret_has_err;
  logic [1:0]  ent_dst_pl, cur_pl, out_pl;
  logic [31:0] ent_err, ent_new_esp, cur_esp, cur_eflags, cur_eip;
  logic [15:0] ent_new_ss, cur_ss, cur_cs, out_ss, out_cs;
  logic        mem_wr_en, mem_rd_en, busy, done;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, out_esp, out_eflags, out_eip;
  logic [31:0] mem [0:255];
  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) if (mem_wr_en) mem[mem_addr[9:2]] <= mem_wdata;

  irq_frame_seq dut_i (
    .clk(clk), .rst_n(rst_n), .ent_start(ent_start), .ent_is_trap(ent_is_trap),
    .ent_dst_pl(ent_dst_pl), .ent_has_err(ent_has_err), .ent_err(ent_err),
    .ent_new_esp(ent_new_esp), .ent_new_ss(ent_new_ss), .ret_start(ret_start),
    .ret_has_err(ret_has_err), .cur_pl(cur_pl), .cur_ss(cur_ss), .cur_esp(cur_esp),
    .cur_eflags(cur_eflags), .cur_cs(cur_cs), .cur_eip(cur_eip),
    .mem_wr_en(mem_wr_en), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .out_pl(out_pl), .out_ss(out_ss), .out_esp(out_esp), .out_eflags(out_eflags),
    .out_cs(out_cs), .out_eip(out_eip)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input bit is_ret, output int cyc);
    logic [31:0] pre_fl;
    pre_fl = out_eflags;
    @(negedge clk);
    if (is_ret) ret_start = 1'b1; else ent_start = 1'b1;
    @(negedge clk);
    ent_start = 1'b0; ret_start = 1'b0;
    cyc = 0;
    while (busy && cyc < 40) begin
      if (cyc == 1) begin ent_start = 1'b1; ret_start = 1'b1; end   // R9 noise
      if (cyc == 2) begin ent_start = 1'b0; ret_start = 1'b0; end
      if (done !== 1'b0 || out_eflags !== pre_fl) chk("R8 outputs held while busy", out_eflags, pre_fl);
      cyc++;
      @(negedge clk);
    end
    ent_start = 1'b0; ret_start = 1'b0;
    chk("R7 done pulse after last access", {30'd0, busy, done}, 32'd1);
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ent_start = 0; ret_start = 0; ent_is_trap = 0; ent_has_err = 0;
    ret_has_err = 0; ent_dst_pl = 0; cur_pl = 0; ent_err = 0; ent_new_esp = 0;
    cur_esp = 0; cur_eflags = 0; cur_eip = 0; ent_new_ss = 0; cur_ss = 0; cur_cs = 0;
    for (int k = 0; k < 256; k++) mem[k] = 32'hDEAD_0000 + k;
    repeat (3) @(negedge clk);
    chk("R10 reset busy/done/strobes", {28'd0, busy, done, mem_wr_en, mem_rd_en}, 32'd0);
    chk("R10 reset out_eflags", out_eflags, 32'd0);
    chk("R10 reset out_esp", out_esp, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 idle after release", {31'd0, busy}, 32'd0);

    for (int cp = 0; cp < 4; cp++)
      for (int dp = 0; dp < 4; dp++)
        for (int e = 0; e < 2; e++)
          for (int g = 0; g < 2; g++) begin
            int i, n, cyc, base;
            bit chg;
            logic [31:0] sp0, fl, eip, err, esp0, fin;
            logic [15:0] ss0, nss, cs;
            i = cp * 16 + dp * 4 + e * 2 + g;
            chg = (cp != dp);
            esp0 = 32'h200; sp0 = chg ? 32'h3C0 : esp0;
            fl  = 32'h00A0_0200 | (i << 16) | (i & 1);
            ss0 = 16'h1000 + 16'(i); nss = 16'h2000 + 16'(i);
            cs  = 16'h0800 | 16'(i << 4) | 16'(cp);
            eip = 32'h1000_0000 + i * 16; err = 32'h0000_E000 + i;
            cur_pl = 2'(cp); ent_dst_pl = 2'(dp); ent_has_err = e[0]; ent_is_trap = g[0];
            cur_ss = ss0; cur_esp = esp0; cur_eflags = fl; cur_cs = cs; cur_eip = eip;
            ent_new_esp = sp0; ent_new_ss = nss; ent_err = err;
            n = (chg ? 2 : 0) + 3 + e;
            run_op(1'b0, cyc);
            chk("R7 entry busy cycles", cyc, n);
            base = 0;
            if (chg) begin
              chk("R2 old SS pushed first", mem[(sp0 - 4) >> 2], {16'd0, ss0});
              chk("R2 old ESP pushed second", mem[(sp0 - 8) >> 2], esp0);
              base = 2;
            end
            chk("R1 flags word", mem[(sp0 - 4 * (base + 1)) >> 2], fl);
            chk("R1 selector word", mem[(sp0 - 4 * (base + 2)) >> 2], {16'd0, cs});
            chk("R1 pointer word", mem[(sp0 - 4 * (base + 3)) >> 2], eip);
            if (e) chk("R3 error code last", mem[(sp0 - 4 * (base + 4)) >> 2], err);
            fin = sp0 - 4 * n;
            chk("R4 out_esp after entry", out_esp, fin);
            chk("R4 out_ss after entry", {16'd0, out_ss}, {16'd0, chg ? nss : ss0});
            chk("R4 out_pl after entry", {30'd0, out_pl}, 32'(dp));
            chk("R4 interrupt-enable by gate", out_eflags, g ? fl : (fl & ~32'h200));
            @(negedge clk);
            chk("R9 no restart after noise", {30'd0, busy, done}, 32'd0);

            cur_pl = 2'(dp); cur_esp = fin; cur_ss = chg ? nss : ss0; ret_has_err = e[0];
            cur_eflags = 32'h0; ent_err = 32'h0;
            run_op(1'b1, cyc);
            chk("R7 return busy cycles", cyc, n);
            chk("R5 restored eip", out_eip, eip);
            chk("R5 restored cs", {16'd0, out_cs}, {16'd0, cs});
            chk("R5 restored eflags", out_eflags, fl);
            chk("R5 restored pl", {30'd0, out_pl}, 32'(cp));
            chk("R5 R6 restored esp", out_esp, chg ? esp0 : sp0);
            chk("R5 restored ss", {16'd0, out_ss}, {16'd0, ss0});
            @(negedge clk);
          end

    // R9: both starts together in idle -> entry wins
    cur_pl = 0; ent_dst_pl = 0; ent_has_err = 0; ent_is_trap = 1;
    cur_esp = 32'h100; cur_eflags = 32'h0000_0246; cur_cs = 16'h0008; cur_eip = 32'h55;
    @(negedge clk);
    ent_start = 1'b1; ret_start = 1'b1;
    @(negedge clk);
    ent_start = 1'b0; ret_start = 1'b0;
    chk("R9 entry wins (write strobe)", {31'd0, mem_wr_en}, 32'd1);
    repeat (4) @(negedge clk);
    chk("R9 entry frame top", mem[(32'h100 - 4) >> 2], 32'h0000_0246);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule